// File: doc/BRIEF.md
# Addressed Serial Register Loader

This block is the digital control core of a quad programmable resistor. A host writes it over a three-wire serial link made of an active-low select, a serial clock and a data line. Each word is ten bits long. The leading two bits choose one of four channels, and the trailing eight bits give the position code (0 to 255) for that channel. When the select line returns high, the channel named by the word takes its data. The far end of the shift register drives a serial output, so several devices can sit on one chain and be loaded with a single long frame.

The core runs on a local clock. It synchronises the three link pins and finds their edges. An asynchronous active-low reset puts every channel at midscale. An active-low shutdown input raises a shutdown flag on every channel. The stored codes are kept during shutdown, and the link goes on accepting writes, so the new positions take effect as soon as shutdown is released.

Top module: `pot_serial_core`

## Requirements
- R1: While `cs_n` is low, each rising edge of `sck` shifts `sdi` into a 10-bit register, most significant bit first. On the rising edge of `cs_n` the last ten bits shifted are used as the word, whatever the number of clocks in the frame.
- R2: Word bits [9:8] hold the channel address and bits [7:0] hold the code. Address n loads channel n, which appears on `code[8n+7:8n]`. The other three channels keep their codes.
- R3: A channel code changes only on a rising edge of `cs_n`. While `cs_n` is high, `sck` and `sdi` activity neither shifts the register nor moves `sdo`.
- R4: `sdo` shows the oldest bit in the shift register and is updated only on a falling edge of `sck` while `cs_n` is low. After n rising edges with n of at least 10, it therefore presents the bit shifted in at edge n-9.
- R5: Taking `rst_n` low immediately sets every channel to 0x80, clears the shift register and drives `sdo` to 0. A frame that was in progress loads nothing.
- R6: While `shdn_n` is low, every bit of `shut` is 1 and the channel codes keep their values. While `shdn_n` is high, every bit of `shut` is 0.
- R7: A word written during shutdown updates its channel's code, and that code remains in force after shutdown is released.
- R8: Each of the 256 code values can be stored in and read back from every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low; sets every channel to midscale |
| cs_n | input | 1 | Serial select, active low; its rising edge loads the word |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| shdn_n | input | 1 | Shutdown, active low |
| sdo | output | 1 | Serial data out, for chaining to the next device |
| code | output | 32 | Four 8-bit channel codes, channel n at bits [8n+7:8n] |
| shut | output | 4 | Per-channel shutdown-effective flag |

## Verification
The bench builds the block with its defaults: four channels, 8-bit codes and two synchroniser stages. Those values give the real 10-bit word and all four addresses. Because each write costs only a few hundred local clocks, the bench can sweep all 256 codes, spreading them over the four channels and checking the unaddressed channels after every write. It also sends frames that are too long and too short, toggles the clock while the select line is idle, pulses reset in the middle of a frame, and writes during shutdown. A bench model of the shift register predicts `sdo` after every falling clock edge.

// File: rtl/pot_pkg.sv
package pot_pkg;
    // Edge events recovered from the synchronised serial pins.
    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_rise;
    } pot_edges_t;
endpackage

// File: rtl/pot_in_sync.sv
module pot_in_sync
    import pot_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       sdi,
    output pot_edges_t edges,
    output logic       sdi_s
);
    typedef struct packed {
        logic [STAGES-1:0] cs;
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] dt;
        logic              cs_prev;
        logic              ck_prev;
    } sync_t;

    sync_t st_d, st_q;
    logic  cs_s, ck_s;

    assign cs_s  = st_q.cs[STAGES-1];
    assign ck_s  = st_q.ck[STAGES-1];
    assign sdi_s = st_q.dt[STAGES-1];

    always_comb begin
        st_d       = st_q;
        st_d.cs[0] = cs_n;
        st_d.ck[0] = sck;
        st_d.dt[0] = sdi;
        for (int i = 1; i < STAGES; i++) begin
            st_d.cs[i] = st_q.cs[i-1];
            st_d.ck[i] = st_q.ck[i-1];
            st_d.dt[i] = st_q.dt[i-1];
        end
        st_d.cs_prev = cs_s;
        st_d.ck_prev = ck_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs      <= '1;
            st_q.ck      <= '0;
            st_q.dt      <= '0;
            st_q.cs_prev <= 1'b1;
            st_q.ck_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        edges.sck_rise = ck_s & ~st_q.ck_prev & ~cs_s;
        edges.sck_fall = ~ck_s & st_q.ck_prev & ~cs_s;
        edges.cs_rise  = cs_s & ~st_q.cs_prev;
    end
endmodule

// File: rtl/pot_shift_path.sv
module pot_shift_path
    import pot_pkg::*;
#(
    parameter int WORD = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pot_edges_t      edges,
    input  logic            sdi_s,
    output logic [WORD-1:0] word,
    output logic            sdo
);
    typedef struct packed {
        logic [WORD-1:0] sreg;
        logic            sdo;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (edges.sck_rise) begin
            sh_d.sreg = {sh_q.sreg[WORD-2:0], sdi_s};
        end
        if (edges.sck_fall) begin
            sh_d.sdo = sh_q.sreg[WORD-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign word = sh_q.sreg;
    assign sdo  = sh_q.sdo;
endmodule

// File: rtl/pot_code_bank.sv
module pot_code_bank #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int AW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     data,
    output logic [NCH*DW-1:0] code
);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] ch;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        for (int i = 0; i < NCH; i++) begin
            if (load && (int'(addr) == i)) begin
                bk_d.ch[i] = data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q.ch <= {NCH{MID}};
        end else begin
            bk_q <= bk_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign code[g*DW +: DW] = bk_q.ch[g];
    end
endmodule

// File: rtl/pot_serial_core.sv
module pot_serial_core
    import pot_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              shdn_n,
    output logic              sdo,
    output logic [NCH*DW-1:0] code,
    output logic [NCH-1:0]    shut
);
    localparam int AW   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int WORD = AW + DW;

    pot_edges_t      edg;
    logic            sdi_s;
    logic [WORD-1:0] word;
    logic            load_w;
    logic            sck_fall_w;

    pot_in_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sck   (sck),
        .sdi   (sdi),
        .edges (edg),
        .sdi_s (sdi_s)
    );

    pot_shift_path #(.WORD(WORD)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .edges (edg),
        .sdi_s (sdi_s),
        .word  (word),
        .sdo   (sdo)
    );

    assign load_w     = edg.cs_rise;
    assign sck_fall_w = edg.sck_fall;

    pot_code_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_w),
        .addr  (word[WORD-1 -: AW]),
        .data  (word[DW-1:0]),
        .code  (code)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_shut
        assign shut[g] = ~shdn_n;
    end
endmodule

// File: rtl/pot_serial_core_chk.sv
module pot_serial_core_chk #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shdn_n,
    input logic              sdo,
    input logic [NCH*DW-1:0] code,
    input logic [NCH-1:0]    shut,
    input logic              load,
    input logic              sck_fall
);
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    logic [NCH*DW-1:0] prev_code;
    logic [NCH-1:0]    chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_code <= {NCH{MID}};
        else        prev_code <= code;
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            chg[i] = (prev_code[i*DW +: DW] != code[i*DW +: DW]);
        end
    end

    AST_RESET_MIDSCALE: assert property (@(posedge clk) !rst_n |-> code == {NCH{MID}}) // R5
        else $error("reset midscale violated");
    AST_LOAD_ONLY_ON_CS: assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(code)) // R3
        else $error("code changed without select edge");
    AST_SINGLE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(chg)) // R2
        else $error("more than one channel changed");
    AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) !sck_fall |=> $stable(sdo)) // R4
        else $error("sdo moved without falling clock");
    AST_SHUT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) !shdn_n |-> &shut) // R6
        else $error("shutdown flag missing");
    AST_SHUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) shdn_n |-> shut == '0) // R6
        else $error("shutdown flag stuck");
endmodule

bind pot_serial_core pot_serial_core_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shdn_n   (shdn_n),
    .sdo      (sdo),
    .code     (code),
    .shut     (shut),
    .load     (load_w),
    .sck_fall (sck_fall_w)
);

// File: tb/pot_serial_core_test.sv
module pot_serial_core_test;
    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int WORD = 10;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic shdn_n = 1'b1;
    logic sdo;
    logic [NCH*DW-1:0] code;
    logic [NCH-1:0] shut;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [WORD-1:0] m_sreg;
    logic [DW-1:0]   m_code [NCH];

    always #10 clk = ~clk;

    pot_serial_core #(.NCH(NCH), .DW(DW), .STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .shdn_n(shdn_n), .sdo(sdo), .code(code), .shut(shut)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwait();
        repeat (H) @(negedge clk);
    endtask

    task automatic check_codes(input string req);
        for (int c = 0; c < NCH; c++) chk(req, 32'(code[c*DW +: DW]), 32'(m_code[c]));
    endtask

    task automatic model_reset();
        m_sreg = '0;
        for (int c = 0; c < NCH; c++) m_code[c] = 8'h80;
    endtask

    // Frame of n bits, bits[n-1] sent first; sdo checked after every falling edge.
    task automatic frame(input int n, input logic [31:0] bits);
        cs_n = 1'b0;
        hwait();
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            hwait();
            sck = 1'b1;
            m_sreg = {m_sreg[WORD-2:0], bits[i]};
            hwait();
            sck = 1'b0;
            hwait();
            chk("R4 sdo", 32'(sdo), 32'(m_sreg[WORD-1]));
        end
        cs_n = 1'b1;
        m_code[m_sreg[WORD-1 -: 2]] = m_sreg[DW-1:0];
        hwait();
    endtask

    initial begin
        model_reset();
        #1 rst_n = 1'b0;
        #2;
        chk("R5 reset sdo", 32'(sdo), 32'h0);
        check_codes("R5 reset codes");
        hwait();
        rst_n = 1'b1;
        hwait();
        check_codes("R5 after release");
        chk("R6 shut idle", 32'(shut), 32'h0);

        // R8 / R2: all 256 codes spread across the channels
        for (int k = 0; k < 64; k++) begin
            for (int c = 0; c < NCH; c++) begin
                frame(WORD, 32'({2'(c), 8'(k * 4 + c)}));
                check_codes("R8 R2 sweep");
            end
        end

        // R1: long frame, the last ten bits count
        frame(13, 32'h1ABC);
        chk("R1 long frame", 32'(code[2*DW +: DW]), 32'hBC);
        check_codes("R1 long frame");
        // R1: short frame mixes with previous contents
        frame(6, 32'h2D);
        check_codes("R1 short frame");

        // R3: clock activity with select high is ignored
        begin
            logic sdo_keep;
            sdo_keep = sdo;
            for (int i = 0; i < 10; i++) begin
                sdi = i[0];
                hwait(); sck = 1'b1; hwait(); sck = 1'b0;
            end
            hwait();
            chk("R3 sdo idle", 32'(sdo), 32'(sdo_keep));
            check_codes("R3 codes idle");
            cs_n = 1'b0; hwait(); cs_n = 1'b1; hwait();
            check_codes("R3 empty frame reload");
        end

        // R6 / R7: shutdown
        shdn_n = 1'b0;
        #1;
        chk("R6 shut on", 32'(shut), 32'hF);
        hwait();
        check_codes("R6 codes kept");
        frame(WORD, 32'({2'd1, 8'h5A}));
        chk("R7 write in shutdown", 32'(code[DW +: DW]), 32'h5A);
        chk("R6 shut held", 32'(shut), 32'hF);
        shdn_n = 1'b1;
        hwait();
        chk("R6 shut off", 32'(shut), 32'h0);
        chk("R7 after release", 32'(code[DW +: DW]), 32'h5A);
        check_codes("R7 all");

        // R5: reset in the middle of a frame
        cs_n = 1'b0;
        hwait();
        for (int i = 0; i < 5; i++) begin
            sdi = 1'b1; hwait(); sck = 1'b1; hwait(); sck = 1'b0; hwait();
        end
        rst_n = 1'b0;
        cs_n = 1'b1;
        model_reset();
        #1;
        check_codes("R5 mid-frame reset");
        chk("R5 sdo cleared", 32'(sdo), 32'h0);
        hwait();
        rst_n = 1'b1;
        hwait(); hwait();
        check_codes("R5 no late load");
        frame(WORD, 32'({2'd3, 8'h01}));
        check_codes("R5 R2 after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule